// File: doc/BRIEF.md
# Serial Audio Transmitter

This block is the transmit half of a serial audio port. Software or a DMA engine writes 32-bit sample words into a 32-entry transmit FIFO. The block generates its own bit clock and frame sync and shifts the words onto a single serial data line. The framing is fully programmable through static configuration inputs:

- the bit-clock divider and bit-clock polarity
- the number of words in a frame
- the sync pulse length, polarity and an early option
- the bit order and the index of the first bit sent
- one width for the first word of a frame and a separate width for every later word

The block raises a request while the FIFO fill level is at or below a watermark, so a DMA engine can keep the FIFO topped up. If the FIFO runs dry in the middle of a frame, the block sends zeros for the rest of that frame. It then sets a sticky error flag, which can also drive an interrupt. When the transmitter is disabled, it completes the frame in flight, lets the bit clock stop, and discards whatever is left in the FIFO. The configuration inputs are assumed to be held steady while the transmitter is enabled.

Top module: `audio_tx_port`

## Requirements
- R1: While the bit clock runs, its output toggles every `cfg_div+1` master clocks, so one full period is `(cfg_div+1)*2` clocks. Data and sync change only on the drive edge. The drive edge is the falling pin edge when `cfg_bclk_inv=0`; `cfg_bclk_inv=1` inverts the pin, making the rising pin edge the drive edge.
- R2: The FIFO holds 32 words of 32 bits and is read in write order. `fifo_full` is high at 32 entries, and a write while full is dropped.
- R3: `dma_req` is high exactly when `req_en` is 1 and the fill level is at most `cfg_watermark`.
- R4: A frame has `cfg_frame_words+1` words. Word 0 carries `cfg_w0_bits+1` bits and each later word carries `cfg_wn_bits+1` bits. Every word takes one FIFO entry, and consecutive frames follow with no gap.
- R5: The k-th bit sent of a word (k counting from 0) is entry bit `(cfg_first_bit-k) mod 32` when `cfg_msb_first=1`, and `(cfg_first_bit+k) mod 32` otherwise.
- R6: With `cfg_fs_early=0`, sync is active for the first `cfg_sync_len+1` bit slots of each frame. `fs_o` is active high when `cfg_fs_inv=0` and active low when it is 1.
- R7: With `cfg_fs_early=1`, sync is active from one slot before the first bit of a frame for `cfg_sync_len+1` slots. Before the first frame after idle there is one lead slot with data 0. Between back-to-back frames, the last slot of the previous frame carries the early sync, but only if another frame follows.
- R8: If a word starts while the FIFO is empty, the rest of that frame is sent as zeros and no further entries are taken in that frame. `err_flag` is set and stays set, `irq` follows `err_flag` while `err_irq_en=1`, and data resumes at the next frame start.
- R9: A one-cycle `err_clr` pulse clears `err_flag`. A new underrun in the same cycle wins.
- R10: When `tx_en` falls, the current frame still completes. Once `bclk_en` is also low, the bit clock stops at its idle level and the FIFO is emptied, which leaves `fifo_full=0` and the level at 0.
- R11: After reset, `bclk_o`, `fs_o`, `sd_o`, `err_flag`, `irq`, `fifo_full` and `dma_req` are all 0, given all configuration inputs and `req_en` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmitter enable: frames start while high |
| bclk_en | input | 1 | Keep the bit clock running while idle |
| req_en | input | 1 | Enable the FIFO request output |
| err_irq_en | input | 1 | Route the underrun flag to `irq` |
| cfg_div | input | 8 | Bit clock divider; period is `(cfg_div+1)*2` clocks |
| cfg_bclk_inv | input | 1 | Invert the bit clock pin |
| cfg_frame_words | input | 5 | Words per frame minus one |
| cfg_sync_len | input | 5 | Sync length in bit slots minus one |
| cfg_fs_inv | input | 1 | Sync active low |
| cfg_fs_early | input | 1 | Sync one slot before the frame |
| cfg_msb_first | input | 1 | Bit index steps downward from the first bit |
| cfg_first_bit | input | 5 | Entry bit index sent first in each word |
| cfg_w0_bits | input | 5 | Word 0 width minus one |
| cfg_wn_bits | input | 5 | Width of the other words minus one |
| cfg_watermark | input | 5 | Fill level at or below which `dma_req` is raised |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 32 | FIFO write word |
| err_clr | input | 1 | Clear the underrun flag |
| fifo_full | output | 1 | FIFO holds 32 words |
| dma_req | output | 1 | FIFO request |
| err_flag | output | 1 | Sticky underrun flag |
| irq | output | 1 | Underrun interrupt |
| bclk_o | output | 1 | Bit clock pin |
| fs_o | output | 1 | Frame sync pin |
| sd_o | output | 1 | Serial data pin |

## Verification
The bench builds the block with its default parameters: a 32-deep FIFO and an 8-bit divider. This makes it possible to fill the FIFO completely and confirm that a 33rd write cannot overwrite the oldest entry.

Small divider settings (3 and 2) keep each bit slot short, so the bench can run several whole frames back to back, including the disable at the end of a frame.

Two contrasting framings are used:
- stereo, 24 of 32 bits, MSB-first from bit 31, with an early active-low sync 24 slots long, at the normal clock polarity;
- a three-word frame of 8 and 16 bits, LSB-first from bit 28 so the bit index wraps past 31, with a one-slot active-high sync, at inverted clock polarity.

The second framing also runs dry in its middle frame. This drives the zero-fill, the sticky flag and the resume at the next frame start.

// File: rtl/audio_tx_pkg.sv
// Shared constants and the internal framing configuration bundle of the
// serial audio transmitter. Assumes a power-of-two sample word width.
package audio_tx_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned BIDX_W = $clog2(WORD_W);

    typedef struct packed {
        logic [BIDX_W-1:0] frame_words;  // words per frame minus one
        logic [BIDX_W-1:0] sync_len;     // sync slots minus one
        logic [BIDX_W-1:0] first_bit;    // entry bit sent first
        logic [BIDX_W-1:0] w0_bits;      // word 0 width minus one
        logic [BIDX_W-1:0] wn_bits;      // other word width minus one
        logic              fs_early;     // sync one slot ahead
        logic              msb_first;    // bit index steps downward
    } frame_cfg_t;
endpackage

// File: rtl/atx_fifo.sv
// Transmit sample FIFO: DEPTH words of W bits, combinational read of the
// oldest word. Writes while full are dropped; pop is only requested when
// not empty; flush empties it in one cycle. DEPTH must be a power of two.
module atx_fifo #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    input  logic                         flush,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty
);
    localparam int unsigned AW    = $clog2(DEPTH);
    localparam int unsigned LVL_W = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          push_ok, pop_ok;

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem[rp];

    // Storage write: no reset needed, contents qualified by level.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= wdata;
    end

    // Pointer and fill-level upkeep, flush has priority.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            wp    <= wp + AW'(push_ok);
            rp    <= rp + AW'(pop_ok);
            level <= level + LVL_W'(push_ok) - LVL_W'(pop_ok);
        end
    end
endmodule

// File: rtl/atx_bclk_gen.sv
// Bit clock divider: while run is high the internal clock toggles every
// div+1 master cycles. drive_tick marks the cycle whose edge brings the
// internal clock low, which is where the framer launches the next slot.
// When run is low the clock parks low and the count restarts.
module atx_bclk_gen #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             bclk_int,
    output logic             drive_tick
);
    logic [DIV_W-1:0] dcnt;
    logic             terminal;

    assign terminal   = run && (dcnt == div);
    assign drive_tick = terminal && bclk_int;

    // Half-period counter and clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            dcnt     <= '0;
            bclk_int <= 1'b0;
        end else if (terminal) begin
            dcnt     <= '0;
            bclk_int <= ~bclk_int;
        end else begin
            dcnt     <= dcnt + 1'b1;
        end
    end
endmodule

// File: rtl/atx_framer.sv
// Slot engine: on each drive tick it decides what the next bit slot
// carries (lead slot, first bit of a word, next bit, or stop), pops FIFO
// words, produces serial data and raw (active-high) sync, detects
// underrun and requests a flush when it stops. Assumes cfg is static
// while busy.
module atx_framer
    import audio_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              tx_en,
    input  frame_cfg_t        cfg,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_rdata,
    output logic              fifo_pop,
    output logic              fifo_flush,
    output logic              underrun,
    output logic              busy,
    output logic              sd,
    output logic              sync
);
    localparam int unsigned POS_W = BIDX_W + 1;

    logic              lead, starve;
    logic [BIDX_W-1:0] wi, bcnt, idx;
    logic [POS_W-1:0]  pos;
    logic [WORD_W-1:0] word;

    logic              do_lead, do_word, do_bit, do_stop, frame_start;
    logic [BIDX_W-1:0] nxt_wi, slot_wi, nxt_bcnt, first_step, idx_step;
    logic [POS_W-1:0]  pos_n;
    logic              starve_n, slot_last, sync_n;

    // Next-slot decision taken at a drive tick.
    always_comb begin
        do_lead     = 1'b0;
        do_word     = 1'b0;
        do_bit      = 1'b0;
        do_stop     = 1'b0;
        frame_start = 1'b0;
        if (tick) begin
            if (!busy) begin
                if (tx_en) begin
                    if (cfg.fs_early) begin
                        do_lead = 1'b1;
                    end else begin
                        do_word     = 1'b1;
                        frame_start = 1'b1;
                    end
                end
            end else if (lead) begin
                do_word     = 1'b1;
                frame_start = 1'b1;
            end else if (bcnt != '0) begin
                do_bit = 1'b1;
            end else if (wi != cfg.frame_words) begin
                do_word = 1'b1;
            end else if (tx_en) begin
                do_word     = 1'b1;
                frame_start = 1'b1;
            end else begin
                do_stop = 1'b1;
            end
        end
    end

    // Slot bookkeeping for the slot being launched.
    always_comb begin
        nxt_wi     = frame_start ? '0 : wi + 1'b1;
        slot_wi    = do_word ? nxt_wi : wi;
        nxt_bcnt   = do_word ? ((nxt_wi == '0) ? cfg.w0_bits : cfg.wn_bits)
                             : bcnt - 1'b1;
        pos_n      = frame_start ? '0
                   : ((pos == {POS_W{1'b1}}) ? pos : pos + 1'b1);
        starve_n   = frame_start ? 1'b0 : starve;
        fifo_pop   = do_word && !starve_n && !fifo_empty;
        underrun   = do_word && !starve_n && fifo_empty;
        fifo_flush = do_stop;
        slot_last  = (slot_wi == cfg.frame_words) && (nxt_bcnt == '0);
        sync_n     = cfg.fs_early
                   ? ((pos_n < POS_W'(cfg.sync_len)) || (slot_last && tx_en))
                   : (pos_n <= POS_W'(cfg.sync_len));
        first_step = cfg.msb_first ? cfg.first_bit - 1'b1 : cfg.first_bit + 1'b1;
        idx_step   = cfg.msb_first ? idx - 1'b1 : idx + 1'b1;
    end

    // Slot state and registered pin values, updated on drive ticks only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            lead   <= 1'b0;
            starve <= 1'b0;
            wi     <= '0;
            bcnt   <= '0;
            idx    <= '0;
            pos    <= '0;
            word   <= '0;
            sd     <= 1'b0;
            sync   <= 1'b0;
        end else if (do_lead) begin
            busy <= 1'b1;
            lead <= 1'b1;
            sd   <= 1'b0;
            sync <= 1'b1;
        end else if (do_word) begin
            busy   <= 1'b1;
            lead   <= 1'b0;
            wi     <= nxt_wi;
            bcnt   <= nxt_bcnt;
            pos    <= pos_n;
            starve <= starve_n || underrun;
            sync   <= sync_n;
            idx    <= first_step;
            if (fifo_pop) begin
                word <= fifo_rdata;
                sd   <= fifo_rdata[cfg.first_bit];
            end else begin
                sd   <= 1'b0;
            end
        end else if (do_bit) begin
            bcnt <= nxt_bcnt;
            pos  <= pos_n;
            sync <= sync_n;
            idx  <= idx_step;
            sd   <= starve ? 1'b0 : word[idx];
        end else if (do_stop) begin
            busy <= 1'b0;
            sd   <= 1'b0;
            sync <= 1'b0;
        end
    end
endmodule

// File: rtl/audio_tx_port.sv
// Serial audio transmitter top: FIFO, bit clock divider and slot engine,
// plus the FIFO request, the sticky underrun flag and pin polarities.
// Assumes the cfg_* inputs are stable while tx_en is set or a frame runs.
module audio_tx_port
    import audio_tx_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 32,
    parameter int unsigned DIV_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              bclk_en,
    input  logic              req_en,
    input  logic              err_irq_en,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_bclk_inv,
    input  logic [BIDX_W-1:0] cfg_frame_words,
    input  logic [BIDX_W-1:0] cfg_sync_len,
    input  logic              cfg_fs_inv,
    input  logic              cfg_fs_early,
    input  logic              cfg_msb_first,
    input  logic [BIDX_W-1:0] cfg_first_bit,
    input  logic [BIDX_W-1:0] cfg_w0_bits,
    input  logic [BIDX_W-1:0] cfg_wn_bits,
    input  logic [BIDX_W-1:0] cfg_watermark,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              err_clr,
    output logic              fifo_full,
    output logic              dma_req,
    output logic              err_flag,
    output logic              irq,
    output logic              bclk_o,
    output logic              fs_o,
    output logic              sd_o
);
    localparam int unsigned LVL_W = $clog2(FIFO_DEPTH+1);

    frame_cfg_t        fcfg;
    logic [WORD_W-1:0] fifo_rdata;
    logic [LVL_W-1:0]  fifo_level;
    logic              fifo_empty, fifo_pop, fifo_flush;
    logic              underrun, busy, sync_raw;
    logic              bclk_int, drive_tick, bclk_run;

    assign fcfg = '{frame_words: cfg_frame_words, sync_len: cfg_sync_len,
                    first_bit: cfg_first_bit, w0_bits: cfg_w0_bits,
                    wn_bits: cfg_wn_bits, fs_early: cfg_fs_early,
                    msb_first: cfg_msb_first};

    assign bclk_run = bclk_en || busy;
    assign bclk_o   = bclk_int ^ cfg_bclk_inv;
    assign fs_o     = sync_raw ^ cfg_fs_inv;
    assign dma_req  = req_en && (fifo_level <= LVL_W'(cfg_watermark));
    assign irq      = err_flag && err_irq_en;

    atx_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(wr_en), .wdata(wr_data),
        .pop(fifo_pop), .flush(fifo_flush), .rdata(fifo_rdata),
        .level(fifo_level), .full(fifo_full), .empty(fifo_empty)
    );

    atx_bclk_gen #(.DIV_W(DIV_W)) u_bclk (
        .clk(clk), .rst_n(rst_n), .run(bclk_run), .div(cfg_div),
        .bclk_int(bclk_int), .drive_tick(drive_tick)
    );

    atx_framer u_framer (
        .clk(clk), .rst_n(rst_n), .tick(drive_tick), .tx_en(tx_en),
        .cfg(fcfg), .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata),
        .fifo_pop(fifo_pop), .fifo_flush(fifo_flush), .underrun(underrun),
        .busy(busy), .sd(sd_o), .sync(sync_raw)
    );

    // Sticky underrun flag, new underrun wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        err_flag <= 1'b0;
        else if (underrun) err_flag <= 1'b1;
        else if (err_clr)  err_flag <= 1'b0;
    end
endmodule

// File: rtl/atx_chk.sv
// Protocol checker for audio_tx_port, attached by bind below. Observes
// pins and the signals passed between the FIFO, divider and slot engine.
module atx_chk #(
    parameter int unsigned DEPTH = 32
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bclk_en,
    input logic                       busy,
    input logic                       bclk_int,
    input logic                       sd_o,
    input logic                       sync_raw,
    input logic                       underrun,
    input logic                       err_flag,
    input logic                       fifo_flush,
    input logic                       fifo_pop,
    input logic                       fifo_full,
    input logic [$clog2(DEPTH+1)-1:0] fifo_level
);
    // R1
    data_on_drive_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sd_o) |-> $fell(bclk_int));
    // R6
    sync_on_drive_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sync_raw) |-> $fell(bclk_int));
    // R2
    full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !fifo_pop && !fifo_flush) |=> fifo_full);
    // R2
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= ($clog2(DEPTH+1))'(DEPTH));
    // R8
    underrun_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> err_flag);
    // R10
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |=> (fifo_level == '0));
    // R10
    clock_parks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bclk_en && !busy) |=> !bclk_int);
endmodule

bind audio_tx_port atx_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .busy(busy),
    .bclk_int(bclk_int), .sd_o(sd_o), .sync_raw(sync_raw),
    .underrun(underrun), .err_flag(err_flag), .fifo_flush(fifo_flush),
    .fifo_pop(fifo_pop), .fifo_full(fifo_full), .fifo_level(fifo_level)
);

// File: tb/tb_audio_tx_port.sv
// Scoreboard bench: tasks build the expected slot stream into a queue,
// a monitor pops and compares it at each sampling edge of the bit clock.
module tb_audio_tx_port;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        tx_en = 0, bclk_en = 0, req_en = 0, err_irq_en = 0;
    logic [7:0]  cfg_div = 0;
    logic        cfg_bclk_inv = 0, cfg_fs_inv = 0, cfg_fs_early = 0, cfg_msb_first = 0;
    logic [4:0]  cfg_frame_words = 0, cfg_sync_len = 0, cfg_first_bit = 0;
    logic [4:0]  cfg_w0_bits = 0, cfg_wn_bits = 0, cfg_watermark = 0;
    logic        wr_en = 0, err_clr = 0;
    logic [31:0] wr_data = 0;
    logic        fifo_full, dma_req, err_flag, irq, bclk_o, fs_o, sd_o;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [1:0]  expq[$];   // {sd, fs pin}
    logic [31:0] src[$];
    bit mon_on = 0, synced = 0;
    int slot_cnt = 0;
    logic prev_b = 0;

    audio_tx_port dut (.*);

    always #10 clk = ~clk;  // 50 MHz

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_word(input logic [31:0] w);
        @(negedge clk); wr_en = 1; wr_data = w;
        @(negedge clk); wr_en = 0;
    endtask

    function automatic logic [31:0] pat(input int k);
        return 32'h13579BDF ^ (32'(k) * 32'h01234567);
    endfunction

    // Expected slots of one frame from the current configuration (R4-model).
    task automatic exp_frame(input bit has_next);
        bit starve = 0;
        int p = 0;
        for (int w = 0; w <= int'(cfg_frame_words); w++) begin
            logic [31:0] d;
            int nb;
            nb = (w == 0) ? int'(cfg_w0_bits) + 1 : int'(cfg_wn_bits) + 1;
            if (!starve && src.size() > 0) d = src.pop_front();
            else begin starve = 1; d = 0; end
            for (int k = 0; k < nb; k++) begin
                logic [4:0] bi;
                logic s;
                bit last;
                bi = cfg_msb_first ? cfg_first_bit - 5'(k) : cfg_first_bit + 5'(k);
                last = (w == int'(cfg_frame_words)) && (k == nb - 1);
                s = cfg_fs_early ? ((p < int'(cfg_sync_len)) || (last && has_next))
                                 : (p <= int'(cfg_sync_len));
                expq.push_back({d[bi], s ^ cfg_fs_inv});
                p++;
            end
        end
    endtask

    // Monitor: compare each sampled slot against the scoreboard.
    always @(negedge clk) begin
        if (mon_on && bclk_o != prev_b && bclk_o == ~cfg_bclk_inv) begin
            if (!synced && fs_o == ~cfg_fs_inv) synced = 1;
            if (synced && expq.size() > 0) begin
                logic [1:0] it;
                it = expq.pop_front();
                chk(sd_o == it[1], $sformatf("R5 data bit slot %0d", slot_cnt), sd_o, it[1]);
                chk(fs_o == it[0], $sformatf("R6/R7 sync slot %0d", slot_cnt), fs_o, it[0]);
                slot_cnt++;
            end
        end
        prev_b = bclk_o;
    end

    // R1: cycles between two sampling edges of the bit clock pin.
    task automatic measure(input int exp);
        int n = 0, edges = 0;
        logic pb = bclk_o;
        while (edges < 2) begin
            @(negedge clk);
            if (edges == 1) n++;
            if (bclk_o != pb && bclk_o == ~cfg_bclk_inv) edges++;
            pb = bclk_o;
        end
        chk(n == exp, "R1 bit clock period", n, exp);
    endtask

    task automatic wait_slots(input int n);
        while (slot_cnt < n) @(negedge clk);
    endtask

    // R10: after the stream drains, the clock stays parked.
    task automatic check_stopped();
        bit moved = 0;
        logic b0;
        while (expq.size() > 0) @(negedge clk);
        repeat (40) @(negedge clk);
        b0 = bclk_o;
        repeat (20) begin @(negedge clk); if (bclk_o != b0) moved = 1; end
        chk(!moved && b0 == cfg_bclk_inv, "R10 bit clock stopped", b0, cfg_bclk_inv);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk({bclk_o, fs_o, sd_o, err_flag, irq, fifo_full, dma_req} == 7'b0,
            "R11 reset outputs", {bclk_o, fs_o, sd_o, err_flag, irq, fifo_full, dma_req}, 0);

        // R3 request versus watermark, R2 full and dropped write
        req_en = 1; cfg_watermark = 2;
        @(negedge clk);
        chk(dma_req == 1, "R3 request at empty", dma_req, 1);
        for (int k = 1; k <= 3; k++) push_word(pat(k));
        chk(dma_req == 0, "R3 request above watermark", dma_req, 0);
        req_en = 0;
        @(negedge clk);
        chk(dma_req == 0, "R3 request gated by req_en", dma_req, 0);
        for (int k = 4; k <= 32; k++) push_word(pat(k));
        chk(fifo_full == 1, "R2 full at 32", fifo_full, 1);
        push_word(32'hDEADBEEF);
        chk(fifo_full == 1, "R2 write while full dropped", fifo_full, 1);

        // Stereo framing, early active-low sync, MSB first from bit 31 (R4 R5 R7)
        cfg_div = 3; cfg_bclk_inv = 0; cfg_frame_words = 1; cfg_sync_len = 23;
        cfg_fs_inv = 1; cfg_fs_early = 1; cfg_msb_first = 1; cfg_first_bit = 31;
        cfg_w0_bits = 23; cfg_wn_bits = 23; cfg_watermark = 0; req_en = 1;
        bclk_en = 1;
        measure(8);
        expq.push_back({1'b0, 1'b1 ^ cfg_fs_inv});  // R7 lead slot
        src = {pat(1), pat(2)}; exp_frame(1);
        src = {pat(3), pat(4)}; exp_frame(0);
        synced = 0; slot_cnt = 0; mon_on = 1;
        @(negedge clk); tx_en = 1;
        wait_slots(52);
        tx_en = 0; bclk_en = 0;
        check_stopped();
        chk(fifo_full == 0, "R10 FIFO flushed (not full)", fifo_full, 0);
        chk(dma_req == 1, "R10 FIFO flushed (level 0)", dma_req, 1);
        chk(err_flag == 0, "R8 no underrun in a fed stream", err_flag, 0);
        mon_on = 0;

        // Three-word frame, LSB first with wrap, inverted clock, underrun (R8)
        cfg_div = 2; cfg_bclk_inv = 1; cfg_frame_words = 2; cfg_sync_len = 0;
        cfg_fs_inv = 0; cfg_fs_early = 0; cfg_msb_first = 0; cfg_first_bit = 28;
        cfg_w0_bits = 7; cfg_wn_bits = 15; err_irq_en = 1; req_en = 0;
        for (int k = 41; k <= 44; k++) push_word(pat(k));
        src = {pat(41), pat(42), pat(43)}; exp_frame(1);
        src = {pat(44)};                   exp_frame(1);
        src = {pat(45), pat(46), pat(47)}; exp_frame(0);
        @(negedge clk); prev_b = bclk_o;
        synced = 0; slot_cnt = 0; mon_on = 1;
        bclk_en = 1;
        measure(6);
        tx_en = 1;
        wait_slots(66);
        chk(err_flag == 1, "R8 underrun flag set", err_flag, 1);
        chk(irq == 1, "R8 interrupt raised", irq, 1);
        for (int k = 45; k <= 47; k++) push_word(pat(k));
        wait_slots(83);
        tx_en = 0; bclk_en = 0;
        check_stopped();
        chk(err_flag == 1, "R8 flag sticky", err_flag, 1);
        @(negedge clk); err_clr = 1;
        @(negedge clk); err_clr = 0;
        chk(err_flag == 0, "R9 flag cleared", err_flag, 0);
        chk(irq == 0, "R9 interrupt cleared", irq, 0);
        chk(expq.size() == 0, "R4 all slots seen", expq.size(), 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule